// File: doc/BRIEF.md
# Banked Control Register File

This block is the byte-wide write side of a network controller's register space. A 4-bit offset selects one of sixteen byte locations, and a bank-select register picks which of four register banks those locations belong to. The block holds the transmit and receive control words, a configuration word, a general-purpose word, a control word, the packet number, the interrupt status and mask, and an early-receive threshold. Sixteen-bit words are written one byte at a time, through a low-byte offset and a high-byte offset.

Interrupt status bits are raised by event inputs and cleared by a write-one-to-clear acknowledge. Only a fixed set of bits can be cleared that way. Acknowledging the transmit bit also sends a pop pulse to the transmit-done queue. The interrupt output is the registered OR of the status bits that the mask enables. A write to the memory-management command location is passed on to the allocation unit as a one-cycle command pulse. Locations for features outside this block (multicast filter, management port, station address, EEPROM actions, pointer and data window) accept writes without effect. A write to a location with no meaning sets a sticky error flag.

Top module: `bank_regfile`

## Requirements
- R1: A write to offset 14 loads the bank number from data bits 1:0, whatever the current bank. A write to offset 15 changes nothing.
- R2: In bank 0, offsets 0 and 1 write the low and high bytes of the transmit control word. Offsets 4 and 5 write the low and high bytes of the receive control word.
- R3: A write to bank 0 offset 5 with data bit 7 set (word bit 15) is not stored. At that clock edge it returns every register, pulse, flag and the interrupt output to zero, including the bank number.
- R4: In bank 1, offsets 0/1 write the configuration word, offsets 10/11 write the general-purpose word, and offsets 12/13 write the control word. A low-byte control write stores data with bits 1:0 forced to zero.
- R5: In bank 2, offset 2 stores the packet number and offset 13 stores the interrupt mask, both 8 bits.
- R6: In bank 2, offset 12 clears each status bit whose data bit is 1 and whose bit in the mask 0xD6 is 1. Status bits 0, 3 and 5 are never cleared by it.
- R7: An acknowledge write with data bit 1 (the transmit interrupt) set makes `txdone_pop` high for exactly the one cycle after the write edge.
- R8: Each bit of `irq_set` sets the matching status bit at the next edge. When a bit is set and acknowledged at the same edge, setting wins.
- R9: `irq` equals the OR of (status AND mask) as both stood one clock earlier, so it follows a status or mask change by one cycle.
- R10: In bank 3, offset 12 stores data bits 4:0 as the early-receive threshold.
- R11: A write to bank 2 offset 0 makes `mmu_valid` high for the one cycle after the write edge, with `mmu_cmd` holding data bits 7:5 from then on.
- R12: Writes to bank 0 offsets 10/11, bank 1 offsets 2-9, bank 2 offsets 1 and 3-11, and bank 3 offsets 0-9 and 13 change no output. Writes to bank 0 offsets 2, 3, 6-9, 12, 13 and bank 3 offsets 10, 11 set `bad_access`, which stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Byte write strobe |
| wr_off | input | 4 | Byte offset within the bank |
| wr_data | input | 8 | Write data |
| irq_set | input | 8 | Interrupt event inputs, one per status bit |
| bank_sel | output | 2 | Current bank number |
| tx_ctrl | output | 16 | Transmit control word |
| rx_ctrl | output | 16 | Receive control word |
| cfg_word | output | 16 | Configuration word |
| gp_word | output | 16 | General-purpose word |
| ctl_word | output | 16 | Control word |
| pkt_num | output | 8 | Packet number |
| irq_mask | output | 8 | Interrupt mask |
| irq_stat | output | 8 | Interrupt status |
| rx_thresh | output | 5 | Early-receive threshold |
| irq | output | 1 | Interrupt request |
| mmu_valid | output | 1 | Memory-management command pulse |
| mmu_cmd | output | 3 | Last memory-management command code |
| txdone_pop | output | 1 | Pop pulse to the transmit-done queue |
| bad_access | output | 1 | Sticky undefined-location flag |

## Verification
The bench builds the block with its default parameters: 8-bit data, a 5-bit threshold, clear mask 0xD6, transmit bit 1, soft-reset at word bit 15, and set-over-acknowledge priority. With these values, every one of the 64 bank/offset pairs can be reached by random writes. Random event inputs collide with acknowledges often enough to exercise the priority rule. The high receive-control byte is randomized with bit 7 mostly held low, so that a rare soft reset lands partway through sequences that have built up state. Directed cases cover the control-word bit forcing, the protected status bits and the sticky error flag.

// File: rtl/brf_pkg.sv
package brf_pkg;
   localparam int BANK_W = 2;
   localparam int NWORD  = 5;
   localparam logic [3:0] OFF_BANK = 4'd14;
   localparam logic [3:0] OFF_SKIP = 4'd15;

   typedef enum logic [2:0] {
      W_TX  = 3'd0,
      W_RX  = 3'd1,
      W_CFG = 3'd2,
      W_GP  = 3'd3,
      W_CTL = 3'd4
   } word_e;

   typedef struct packed {
      logic             bank_we;
      logic [NWORD-1:0] lo_we;
      logic [NWORD-1:0] hi_we;
      logic             pkt_we;
      logic             mask_we;
      logic             ack_we;
      logic             thr_we;
      logic             mmu_we;
      logic             bad;
   } dec_t;
endpackage

// File: rtl/brf_decode.sv
module brf_decode
   import brf_pkg::*;
(
   input  logic              wr_en,
   input  logic [BANK_W-1:0] bank,
   input  logic [3:0]        off,
   output dec_t              dec
);
   always_comb begin
      dec = '0;
      if (wr_en) begin
         if (off == OFF_BANK) begin
            dec.bank_we = 1'b1;
         end else if (off != OFF_SKIP) begin
            case (bank)
               2'd0: begin
                  case (off)
                     4'd0:         dec.lo_we[W_TX] = 1'b1;
                     4'd1:         dec.hi_we[W_TX] = 1'b1;
                     4'd4:         dec.lo_we[W_RX] = 1'b1;
                     4'd5:         dec.hi_we[W_RX] = 1'b1;
                     4'd10, 4'd11: ; // accepted, no effect (R12)
                     default:      dec.bad = 1'b1;
                  endcase
               end
               2'd1: begin
                  case (off)
                     4'd0:         dec.lo_we[W_CFG] = 1'b1;
                     4'd1:         dec.hi_we[W_CFG] = 1'b1;
                     4'd10:        dec.lo_we[W_GP]  = 1'b1;
                     4'd11:        dec.hi_we[W_GP]  = 1'b1;
                     4'd12:        dec.lo_we[W_CTL] = 1'b1;
                     4'd13:        dec.hi_we[W_CTL] = 1'b1;
                     default:      ; // offsets 2..9 accepted, no effect
                  endcase
               end
               2'd2: begin
                  case (off)
                     4'd0:    dec.mmu_we  = 1'b1;
                     4'd2:    dec.pkt_we  = 1'b1;
                     4'd12:   dec.ack_we  = 1'b1;
                     4'd13:   dec.mask_we = 1'b1;
                     default: ; // 1, 3..11 accepted, no effect
                  endcase
               end
               default: begin
                  case (off)
                     4'd12:        dec.thr_we = 1'b1;
                     4'd10, 4'd11: dec.bad    = 1'b1;
                     default:      ; // 0..9, 13 accepted, no effect
                  endcase
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/brf_word16.sv
module brf_word16 #(
   parameter int               DATA_W   = 8,
   parameter logic [DATA_W-1:0] FORCE_LO = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr,
   input  logic                  lo_we,
   input  logic                  hi_we,
   input  logic [DATA_W-1:0]     d,
   output logic [2*DATA_W-1:0]   q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (clr) begin
         q <= '0;
      end else begin
         if (lo_we) q[DATA_W-1:0]        <= d & ~FORCE_LO;
         if (hi_we) q[2*DATA_W-1:DATA_W] <= d;
      end
   end

   // R4: forced low bits never stored on a low-byte write
   p_force_lo_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_we && !clr) |=> q[DATA_W-1:0] == ($past(d) & ~FORCE_LO));

   // R2: high byte takes the written data
   p_hi_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_we && !clr) |=> q[2*DATA_W-1:DATA_W] == $past(d));
endmodule

// File: rtl/brf_irq.sv
module brf_irq #(
   parameter int                IRQ_W    = 8,
   parameter logic [IRQ_W-1:0]  ACK_MASK = 8'hD6,
   parameter int                TX_BIT   = 1,
   parameter bit                SET_WINS = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [IRQ_W-1:0] set,
   input  logic             ack_we,
   input  logic             mask_we,
   input  logic [IRQ_W-1:0] d,
   output logic [IRQ_W-1:0] stat_q,
   output logic [IRQ_W-1:0] mask_q,
   output logic             irq,
   output logic             pop
);
   logic [IRQ_W-1:0] clr_bits;
   logic [IRQ_W-1:0] stat_nxt;

   assign clr_bits = ack_we ? (d & ACK_MASK) : '0;

   generate
      if (SET_WINS) begin : g_set_wins
         assign stat_nxt = (stat_q & ~clr_bits) | set;
      end else begin : g_ack_wins
         assign stat_nxt = (stat_q | set) & ~clr_bits;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q <= '0;
         mask_q <= '0;
         irq    <= 1'b0;
         pop    <= 1'b0;
      end else if (clr) begin
         stat_q <= '0;
         mask_q <= '0;
         irq    <= 1'b0;
         pop    <= 1'b0;
      end else begin
         stat_q <= stat_nxt;
         if (mask_we) mask_q <= d;
         irq <= |(stat_q & mask_q);
         pop <= ack_we & d[TX_BIT];
      end
   end

   // R6: acknowledged clearable bits drop unless re-raised
   p_ack_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && set == '0) |=> (stat_q & $past(d & ACK_MASK)) == '0);

   // R6: protected bits survive an acknowledge
   p_ack_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && !clr) |=> (stat_q & ~ACK_MASK) == ($past((stat_q | set) & ~ACK_MASK)));

   // R7: transmit acknowledge pops the done queue
   p_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_we && d[TX_BIT] && !clr) |=> pop);

   // R9: interrupt follows status and mask one cycle later
   p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr) |=> irq == (|($past(stat_q & mask_q))));

   generate
      if (SET_WINS) begin : g_chk_set
         // R8: event inputs win over a same-cycle acknowledge
         p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr) |=> (stat_q & $past(set)) == $past(set));
      end
   endgenerate
endmodule

// File: rtl/bank_regfile.sv
module bank_regfile
   import brf_pkg::*;
#(
   parameter int               DATA_W    = 8,
   parameter int               THR_W     = 5,
   parameter int               CMD_W     = 3,
   parameter logic [DATA_W-1:0] ACK_MASK = 8'hD6,
   parameter int               TX_BIT    = 1,
   parameter int               SOFT_BIT  = 15,
   parameter logic [DATA_W-1:0] CTL_FORCE = 8'h03,
   parameter bit               SET_WINS  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [3:0]          wr_off,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [DATA_W-1:0]   irq_set,
   output logic [BANK_W-1:0]   bank_sel,
   output logic [2*DATA_W-1:0] tx_ctrl,
   output logic [2*DATA_W-1:0] rx_ctrl,
   output logic [2*DATA_W-1:0] cfg_word,
   output logic [2*DATA_W-1:0] gp_word,
   output logic [2*DATA_W-1:0] ctl_word,
   output logic [DATA_W-1:0]   pkt_num,
   output logic [DATA_W-1:0]   irq_mask,
   output logic [DATA_W-1:0]   irq_stat,
   output logic [THR_W-1:0]    rx_thresh,
   output logic                irq,
   output logic                mmu_valid,
   output logic [CMD_W-1:0]    mmu_cmd,
   output logic                txdone_pop,
   output logic                bad_access
);
   localparam int WORD_W   = 2 * DATA_W;
   localparam int SOFT_IDX = SOFT_BIT - DATA_W;
   localparam int CMD_LSB  = DATA_W - CMD_W;

   generate
      if (DATA_W != 8) begin : g_err_dw
         $error("bank_regfile: DATA_W must be 8");
      end
      if (THR_W < 1 || THR_W > DATA_W) begin : g_err_thr
         $error("bank_regfile: THR_W out of range");
      end
      if (CMD_W < 1 || CMD_W > DATA_W) begin : g_err_cmd
         $error("bank_regfile: CMD_W out of range");
      end
      if (SOFT_BIT < DATA_W || SOFT_BIT >= WORD_W) begin : g_err_soft
         $error("bank_regfile: SOFT_BIT must sit in the high byte");
      end
      if (TX_BIT < 0 || TX_BIT >= DATA_W) begin : g_err_tx
         $error("bank_regfile: TX_BIT out of range");
      end
   endgenerate

   dec_t dec;
   logic srst;
   logic [BANK_W-1:0] bank_q;
   logic [NWORD-1:0][WORD_W-1:0] words;
   logic bad_q;

   brf_decode u_dec (
      .wr_en (wr_en),
      .bank  (bank_q),
      .off   (wr_off),
      .dec   (dec)
   );

   assign srst = dec.hi_we[W_RX] & wr_data[SOFT_IDX];

   genvar gi;
   generate
      for (gi = 0; gi < NWORD; gi++) begin : g_word
         localparam logic [DATA_W-1:0] FMASK = (gi == int'(W_CTL)) ? CTL_FORCE : '0;
         brf_word16 #(
            .DATA_W   (DATA_W),
            .FORCE_LO (FMASK)
         ) u_w (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (srst),
            .lo_we (dec.lo_we[gi]),
            .hi_we (dec.hi_we[gi] & ~srst),
            .d     (wr_data),
            .q     (words[gi])
         );
      end
   endgenerate

   brf_irq #(
      .IRQ_W    (DATA_W),
      .ACK_MASK (ACK_MASK),
      .TX_BIT   (TX_BIT),
      .SET_WINS (SET_WINS)
   ) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (srst),
      .set     (irq_set),
      .ack_we  (dec.ack_we),
      .mask_we (dec.mask_we),
      .d       (wr_data),
      .stat_q  (irq_stat),
      .mask_q  (irq_mask),
      .irq     (irq),
      .pop     (txdone_pop)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bank_q    <= '0;
         pkt_num   <= '0;
         rx_thresh <= '0;
         mmu_valid <= 1'b0;
         mmu_cmd   <= '0;
         bad_q     <= 1'b0;
      end else if (srst) begin
         bank_q    <= '0;
         pkt_num   <= '0;
         rx_thresh <= '0;
         mmu_valid <= 1'b0;
         mmu_cmd   <= '0;
         bad_q     <= 1'b0;
      end else begin
         if (dec.bank_we) bank_q    <= wr_data[BANK_W-1:0];
         if (dec.pkt_we)  pkt_num   <= wr_data;
         if (dec.thr_we)  rx_thresh <= wr_data[THR_W-1:0];
         mmu_valid <= dec.mmu_we;
         if (dec.mmu_we)  mmu_cmd   <= wr_data[DATA_W-1:CMD_LSB];
         if (dec.bad)     bad_q     <= 1'b1;
      end
   end

   assign bank_sel   = bank_q;
   assign tx_ctrl    = words[W_TX];
   assign rx_ctrl    = words[W_RX];
   assign cfg_word   = words[W_CFG];
   assign gp_word    = words[W_GP];
   assign ctl_word   = words[W_CTL];
   assign bad_access = bad_q;

   // R1: bank select from any bank
   p_bank_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_off == OFF_BANK) |=> bank_sel == $past(wr_data[BANK_W-1:0]));

   // R1: offset 15 leaves the register state alone
   p_skip_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_off == OFF_SKIP) |=> $stable(bank_sel) && $stable(words) && $stable(pkt_num)
                                        && $stable(rx_thresh) && $stable(irq_mask));

   // R3: soft reset clears the whole block
   p_soft_r3: assert property (@(posedge clk) disable iff (!rst_n)
      srst |=> (words == '0) && (bank_sel == '0) && !bad_access && !irq && (irq_stat == '0));

   // R10: threshold keeps the low bits of the write
   p_thr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bank_sel == 2'd3 && wr_off == 4'd12) |=> rx_thresh == $past(wr_data[THR_W-1:0]));

   // R11: command write produces a one-cycle pulse with its code
   p_mmu_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && bank_sel == 2'd2 && wr_off == 4'd0) |=> mmu_valid && mmu_cmd == $past(wr_data[DATA_W-1:CMD_LSB]));

   // R12: error flag is sticky until reset
   p_bad_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_access && !srst) |=> bad_access);
endmodule

// File: tb/sim_bank_regfile.sv
`timescale 1ns/1ps
module sim_bank_regfile;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_off = '0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  irq_set = '0;
   logic [1:0]  bank_sel;
   logic [15:0] tx_ctrl, rx_ctrl, cfg_word, gp_word, ctl_word;
   logic [7:0]  pkt_num, irq_mask, irq_stat;
   logic [4:0]  rx_thresh;
   logic        irq, mmu_valid, txdone_pop, bad_access;
   logic [2:0]  mmu_cmd;

   bank_regfile u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
      .irq_set(irq_set), .bank_sel(bank_sel), .tx_ctrl(tx_ctrl), .rx_ctrl(rx_ctrl),
      .cfg_word(cfg_word), .gp_word(gp_word), .ctl_word(ctl_word), .pkt_num(pkt_num),
      .irq_mask(irq_mask), .irq_stat(irq_stat), .rx_thresh(rx_thresh), .irq(irq),
      .mmu_valid(mmu_valid), .mmu_cmd(mmu_cmd), .txdone_pop(txdone_pop),
      .bad_access(bad_access)
   );

   always #4 clk = ~clk;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // bench model
   logic [1:0]  m_bank;
   logic [15:0] m_tx, m_rx, m_cfg, m_gp, m_ctl;
   logic [7:0]  m_pkt, m_mask, m_stat;
   logic [4:0]  m_thr;
   logic [2:0]  m_cmd;
   logic        m_bad, e_irq, e_pop, e_mv;

   task automatic model_clear();
      m_bank = '0; m_tx = '0; m_rx = '0; m_cfg = '0; m_gp = '0; m_ctl = '0;
      m_pkt = '0; m_mask = '0; m_stat = '0; m_thr = '0; m_cmd = '0;
      m_bad = 1'b0; e_irq = 1'b0; e_pop = 1'b0; e_mv = 1'b0;
   endtask

   function automatic bit soft_hit(logic [1:0] b, logic [3:0] o, logic [7:0] d, bit we);
      return we && b == 2'd0 && o == 4'd5 && d[7];
   endfunction

   task automatic model_step(bit we, logic [3:0] o, logic [7:0] d, logic [7:0] s);
      logic [7:0] ackclr;
      ackclr = '0;
      e_irq = |(m_stat & m_mask);
      e_pop = 1'b0;
      e_mv  = 1'b0;
      if (soft_hit(m_bank, o, d, we)) begin
         model_clear(); // R3
         return;
      end
      if (we) begin
         if (o == 4'd14) m_bank = d[1:0];
         else if (o != 4'd15) begin
            case (m_bank)
               2'd0: case (o)
                  4'd0: m_tx[7:0] = d;
                  4'd1: m_tx[15:8] = d;
                  4'd4: m_rx[7:0] = d;
                  4'd5: m_rx[15:8] = d;
                  4'd10, 4'd11: ;
                  default: m_bad = 1'b1;
               endcase
               2'd1: case (o)
                  4'd0: m_cfg[7:0] = d;
                  4'd1: m_cfg[15:8] = d;
                  4'd10: m_gp[7:0] = d;
                  4'd11: m_gp[15:8] = d;
                  4'd12: m_ctl[7:0] = d & 8'hFC;
                  4'd13: m_ctl[15:8] = d;
                  default: ;
               endcase
               2'd2: case (o)
                  4'd0: begin e_mv = 1'b1; m_cmd = d[7:5]; end
                  4'd2: m_pkt = d;
                  4'd12: begin ackclr = d & 8'hD6; e_pop = d[1]; end
                  4'd13: m_mask = d;
                  default: ;
               endcase
               default: case (o)
                  4'd12: m_thr = d[4:0];
                  4'd10, 4'd11: m_bad = 1'b1;
                  default: ;
               endcase
            endcase
         end
      end
      m_stat = (m_stat & ~ackclr) | s;
   endtask

   task automatic chk(string req, string nm, int act, int exp);
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, nm, act, exp);
      end
   endtask

   task automatic compare_all();
      n_vec++;
      chk("R1",  "bank",   bank_sel,   m_bank);
      chk("R2",  "tx",     tx_ctrl,    m_tx);
      chk("R2",  "rx",     rx_ctrl,    m_rx);
      chk("R4",  "cfg",    cfg_word,   m_cfg);
      chk("R4",  "gp",     gp_word,    m_gp);
      chk("R4",  "ctl",    ctl_word,   m_ctl);
      chk("R5",  "pkt",    pkt_num,    m_pkt);
      chk("R5",  "mask",   irq_mask,   m_mask);
      chk("R6",  "stat",   irq_stat,   m_stat);
      chk("R7",  "pop",    txdone_pop, e_pop);
      chk("R9",  "irq",    irq,        e_irq);
      chk("R10", "thr",    rx_thresh,  m_thr);
      chk("R11", "mmu_v",  mmu_valid,  e_mv);
      chk("R11", "mmu_c",  mmu_cmd,    m_cmd);
      chk("R12", "bad",    bad_access, m_bad);
   endtask

   // called at a falling edge; returns at the next falling edge
   task automatic step(bit we, logic [3:0] o, logic [7:0] d, logic [7:0] s);
      wr_en = we; wr_off = o; wr_data = d; irq_set = s;
      model_step(we, o, d, s);
      @(negedge clk);
      compare_all();
      wr_en = 1'b0; irq_set = '0;
   endtask

   task automatic wr(logic [3:0] o, logic [7:0] d);
      step(1'b1, o, d, 8'h00);
   endtask

   initial begin
      #(8.0 * 200000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_2024));
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      compare_all(); // reset state

      // R1: bank select, offset 15 ignored
      wr(4'd14, 8'hFE);            // bank 2
      wr(4'd15, 8'h01);
      chk("R1", "skip15", bank_sel, 2);
      // R2: bank 0 words
      wr(4'd14, 8'h00);
      wr(4'd0, 8'h34); wr(4'd1, 8'h12); wr(4'd4, 8'h78); wr(4'd5, 8'h56);
      // R12: ignored vs undefined in bank 0
      wr(4'd10, 8'hFF); wr(4'd11, 8'hFF);
      chk("R12", "no_bad", bad_access, 0);
      // R4: control word forcing
      wr(4'd14, 8'h01);
      wr(4'd12, 8'hFF); wr(4'd13, 8'hA5);
      chk("R4", "ctl_forced", ctl_word, 16'hA5FC);
      wr(4'd3, 8'h99);             // accepted, no effect
      // R5, R6, R7, R8, R9 in bank 2
      wr(4'd14, 8'h02);
      wr(4'd2, 8'h3C);
      step(1'b0, 4'd0, 8'h00, 8'hFF);      // raise every status bit
      wr(4'd13, 8'h01);                      // mask bit 0 only
      step(1'b0, 4'd0, 8'h00, 8'h00);        // irq visible
      chk("R9", "irq_on", irq, 1);
      wr(4'd12, 8'hFF);                      // ack all: 0,3,5 remain
      chk("R6", "protected", irq_stat, 8'h29);
      step(1'b1, 4'd12, 8'h02, 8'h02);       // R8 set wins over ack
      chk("R8", "set_wins", irq_stat[1], 1);
      wr(4'd0, 8'hC0);                       // R11 command 6
      // R10 and R12 in bank 3
      wr(4'd14, 8'h03);
      wr(4'd12, 8'hFF);
      wr(4'd10, 8'h00);
      chk("R12", "bad_set", bad_access, 1);
      wr(4'd14, 8'h00);
      wr(4'd0, 8'h11);
      chk("R12", "bad_sticky", bad_access, 1);
      // R3: soft reset
      wr(4'd5, 8'h80);
      chk("R3", "soft_tx", tx_ctrl, 0);
      chk("R3", "soft_bad", bad_access, 0);

      for (int i = 0; i < 4000; i++) begin
         logic [3:0] o;
         logic [7:0] d, s;
         bit we;
         we = ($urandom % 8) != 0;
         o  = 4'($urandom % 16);
         d  = 8'($urandom);
         s  = (($urandom % 4) == 0) ? 8'($urandom & $urandom) : 8'h00;
         if (m_bank == 2'd0 && o == 4'd5 && ($urandom % 60) != 0) d[7] = 1'b0;
         step(we, o, d, s);
      end

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule